// File: doc/BRIEF.md
# Eye Center Delay Optimizer

This block finds the centre of the valid data window on a serial receive lane. A training pattern arrives as a 10-bit deserialized word in which one bit carries a pulse. The block steps an external delay line one tap at a time, waits for the line to settle after each step, and follows a single bit position of the word across the sweep. It records the first tap at which that bit shows up and how many further consecutive taps it stays set. From this it computes the tap in the middle of that window.

The surrounding logic applies the increment to the delay line whenever `inc_en` pulses and feeds the current tap value back on `tap_in`. Once `done` rises, the results stay frozen until the next reset. Writing the chosen tap into the delay line is left to the surrounding logic.

Top module: `eco_delay_optimizer`

## Requirements
- R1: While reset is held and right after it, `done` and `inc_en` are 0 and `pulse_idx`, `min_dly`, `max_ofs` and `opt_tap` are all 0.
- R2: The tracked bit index `pulse_idx` equals the position of the lowest set bit of `rx_word` at the first evaluated tap, plus one, wrapping from 9 to 0.
- R3: `min_dly` holds the value of `tap_in` at the first evaluation where the tracked bit of `rx_word` is 1. This can be tap 0.
- R4: `max_ofs` counts the further consecutive evaluations after `min_dly` in which the tracked bit stays 1.
- R5: The sweep ends with `done` at the first evaluation where the tracked bit is 0 after having been seen. No `inc_en` is issued for that tap, so the number of `inc_en` pulses equals that tap value when the sweep starts at tap 0.
- R6: If the evaluation at tap 31 is reached without the window closing, the sweep ends there and includes tap 31 in the window. If the bit was never seen, `min_dly`, `max_ofs` and `opt_tap` stay 0.
- R7: `opt_tap` equals `min_dly` plus `max_ofs` divided by two, rounded down.
- R8: `inc_en` is high for exactly one cycle per step. After each step the block waits a settle time of 2 cycles plus one evaluation cycle, so consecutive `inc_en` pulses are at least 4 cycles apart.
- R9: After `done`, the outputs `pulse_idx`, `min_dly`, `max_ofs` and `opt_tap` stay unchanged, `done` stays 1 and `inc_en` stays 0, whatever `start`, `tap_in` and `rx_word` do.
- R10: Until `start` is seen high, the block issues no `inc_en` and keeps `done` low, whatever `rx_word` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Level; begins the sweep when seen high in idle |
| tap_in | input | 5 | Current tap of the external delay line |
| rx_word | input | 10 | Deserialized training word |
| inc_en | output | 1 | One-cycle request to advance the delay line by one tap |
| done | output | 1 | Sweep finished; results valid and frozen |
| pulse_idx | output | 4 | Bit position being tracked |
| min_dly | output | 5 | First tap where the tracked bit was set |
| max_ofs | output | 5 | Further consecutive taps with the bit set |
| opt_tap | output | 5 | Centre tap of the measured window |

## Verification
The hardest cases to reach are the two ends of the tap range. In one, the window is still open at tap 31 and has to be closed by the tap limit. In the other, the tracked bit is already set at tap 0, so the index is picked and the window opened by the same evaluation. The bench models the delay line as a counter that advances on each `inc_en`. It derives each word from a base pulse bit plus a neighbouring bit that is present over a chosen tap range. Vectors place that range to start at tap 0, to run past tap 31, to start exactly at tap 31, and to lie outside the sweep entirely.

// File: rtl/eco_pkg.sv
package eco_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_EVAL   = 3'd2,
    ST_STEP   = 3'd3,
    ST_FIN    = 3'd4
  } eco_state_e;
endpackage

// File: rtl/eco_settle_timer.sv
module eco_settle_timer #(
  parameter int unsigned CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == CW'(CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: expiry only follows a cycle in which the timer was already running
  p_expire_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(run));
endmodule

// File: rtl/eco_pulse_locator.sv
module eco_pulse_locator #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  next_idx
);
  logic [IDX_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (word[i]) low_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (low_idx == IDX_W'(WORD_W - 1)) next_idx = '0;
    else                               next_idx = low_idx + IDX_W'(1);
  end
endmodule

// File: rtl/eco_window_tracker.sv
module eco_window_tracker #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned TAP_W  = 5,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [TAP_W-1:0]  tap,
  input  logic [IDX_W-1:0]  first_idx,
  output logic [IDX_W-1:0]  idx_q,
  output logic [TAP_W-1:0]  min_q,
  output logic [TAP_W-1:0]  ofs_q,
  output logic              closes
);
  logic             first_q, first_d;
  logic             found_q, found_d;
  logic [IDX_W-1:0] idx_d, idx_cur;
  logic [TAP_W-1:0] min_d, ofs_d;
  logic             hit;

  assign idx_cur = first_q ? first_idx : idx_q;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (idx_cur == IDX_W'(i)) hit = rx_word[i];
    end
  end

  assign closes = found_q && !hit;

  always_comb begin
    first_d = first_q;
    found_d = found_q;
    idx_d   = idx_q;
    min_d   = min_q;
    ofs_d   = ofs_q;
    if (eval_en) begin
      first_d = 1'b0;
      idx_d   = idx_cur;
      if (hit) begin
        if (!found_q) begin
          found_d = 1'b1;
          min_d   = tap;
          ofs_d   = '0;
        end else begin
          ofs_d   = ofs_q + TAP_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      found_q <= 1'b0;
      idx_q   <= '0;
      min_q   <= '0;
      ofs_q   <= '0;
    end else if (eval_en) begin
      first_q <= first_d;
      found_q <= found_d;
      idx_q   <= idx_d;
      min_q   <= min_d;
      ofs_q   <= ofs_d;
    end
  end

  // R3: once the window has opened its start tap is never rewritten
  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |=> $stable(min_q));
  // R4: a further set sample extends the window by exactly one
  p_ofs_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && found_q && hit) |=> (ofs_q == $past(ofs_q) + TAP_W'(1)));
  // R4: the window never reaches past the last tap
  p_ofs_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (({1'b0, min_q} + {1'b0, ofs_q}) <= (TAP_W + 1)'((1 << TAP_W) - 1)));
  // R2: the tracked index stays inside the word
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(WORD_W));
endmodule

// File: rtl/eco_delay_optimizer.sv
module eco_delay_optimizer
  import eco_pkg::*;
#(
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned TAP_W      = 5,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAP_W-1:0]  tap_in,
  input  logic [WORD_W-1:0] rx_word,
  output logic              inc_en,
  output logic              done,
  output logic [IDX_W-1:0]  pulse_idx,
  output logic [TAP_W-1:0]  min_dly,
  output logic [TAP_W-1:0]  max_ofs,
  output logic [TAP_W-1:0]  opt_tap
);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'((1 << TAP_W) - 1);

  logic       rst_meta_q, rst_sync_q;
  eco_state_e state_q, state_d;
  logic       tmr_run, tmr_exp;
  logic       eval_en, trk_close;
  logic [IDX_W-1:0] loc_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign tmr_run = (state_q == ST_SETTLE);
  assign eval_en = (state_q == ST_EVAL);

  eco_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  eco_pulse_locator #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_locator (
    .word     (rx_word),
    .next_idx (loc_idx)
  );

  eco_window_tracker #(.WORD_W(WORD_W), .TAP_W(TAP_W), .IDX_W(IDX_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .eval_en   (eval_en),
    .rx_word   (rx_word),
    .tap       (tap_in),
    .first_idx (loc_idx),
    .idx_q     (pulse_idx),
    .min_q     (min_dly),
    .ofs_q     (max_ofs),
    .closes    (trk_close)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_SETTLE;
      ST_SETTLE: if (tmr_exp) state_d = ST_EVAL;
      ST_EVAL:   state_d = (trk_close || (tap_in == LAST_TAP)) ? ST_FIN : ST_STEP;
      ST_STEP:   state_d = ST_SETTLE;
      ST_FIN:    state_d = ST_FIN;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  assign inc_en  = (state_q == ST_STEP);
  assign done    = (state_q == ST_FIN);
  assign opt_tap = min_dly + (max_ofs >> 1);

  // R8: the delay line is advanced for one cycle at a time
  p_inc_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    inc_en |=> !inc_en);
  // R8: every evaluation is preceded by the settle wait
  p_eval_after_settle_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    eval_en |-> ($past(state_q) == ST_SETTLE));
  // R9: results hold once the sweep has ended
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |=> (done && !inc_en && $stable(pulse_idx) && $stable(min_dly) && $stable(max_ofs)));
  // R7: the chosen tap lies inside the measured window
  p_opt_inside_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> ((opt_tap >= min_dly) &&
              ({1'b0, opt_tap} <= ({1'b0, min_dly} + {1'b0, max_ofs}))));
endmodule

// File: tb/eco_delay_optimizer_tb_top.sv
`timescale 1ns/1ps
module eco_delay_optimizer_tb_top;
  localparam int WORD_W = 10;
  localparam int TAP_W  = 5;
  localparam int IDX_W  = 4;
  localparam int NVEC   = 8;
  localparam int WATCHDOG_CYC = 150000;

  // base bit, first tap of neighbour bit, span, exp idx, exp min, exp ofs, exp opt, exp final tap
  localparam int VEC [NVEC][8] = '{
    '{3,  5,  8, 4,  5,  7,  8, 13},
    '{9,  2,  1, 0,  2,  0,  2,  3},
    '{0, 20, 20, 1, 20, 11, 25, 31},
    '{6,  1,  6, 7,  1,  5,  3,  7},
    '{2, 10,  5, 3, 10,  4, 12, 15},
    '{8, 31,  3, 9, 31,  0, 31, 31},
    '{4, 40,  0, 5,  0,  0,  0, 31},
    '{3,  0,  4, 4,  0,  3,  1,  4}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [TAP_W-1:0]  tap_in;
  logic [WORD_W-1:0] rx_word;
  logic              inc_en, done;
  logic [IDX_W-1:0]  pulse_idx;
  logic [TAP_W-1:0]  min_dly, max_ofs, opt_tap;

  int n_chk = 0;
  int n_bad = 0;
  int incs, last_inc_cyc, min_gap, cyc;

  always #2.5 clk = ~clk;

  eco_delay_optimizer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tap_in    (tap_in),
    .rx_word   (rx_word),
    .inc_en    (inc_en),
    .done      (done),
    .pulse_idx (pulse_idx),
    .min_dly   (min_dly),
    .max_ofs   (max_ofs),
    .opt_tap   (opt_tap)
  );

  function automatic logic [WORD_W-1:0] word_at(int b, int f, int w, int t);
    logic [WORD_W-1:0] v;
    v = '0;
    v[b] = 1'b1;
    if (t >= f && t < f + w) v[(b + 1) % WORD_W] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int b, input int f, input int w);
    rst_n   = 1'b0;
    start   = 1'b0;
    tap_in  = '0;
    rx_word = word_at(b, f, w, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sweep(input int b, input int f, input int w);
    start = 1'b1;
    incs = 0;
    last_inc_cyc = -100;
    min_gap = 1000;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (inc_en) begin
        if (cyc - last_inc_cyc < min_gap) min_gap = cyc - last_inc_cyc;
        last_inc_cyc = cyc;
        incs++;
        tap_in  = tap_in + TAP_W'(1);
        rx_word = word_at(b, f, w, int'(tap_in));
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(3, 5, 8);
    check("R1 done", int'(done), 0);
    check("R1 inc_en", int'(inc_en), 0);
    check("R1 outputs", int'({pulse_idx, min_dly, max_ofs, opt_tap}), 0);

    // R10: idle without start, busy word
    begin
      int seen = 0;
      for (int k = 0; k < 25; k++) begin
        rx_word = WORD_W'(10'h2A5 ^ k);
        @(negedge clk);
        if (inc_en || done) seen++;
      end
      check("R10 idle activity", seen, 0);
    end

    // table walk: R2..R8
    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][0], VEC[v][1], VEC[v][2]);
      sweep(VEC[v][0], VEC[v][1], VEC[v][2]);
      check("R5 done", int'(done), 1);
      check("R2 pulse_idx", int'(pulse_idx), VEC[v][3]);
      check("R3 min_dly", int'(min_dly), VEC[v][4]);
      check("R4 max_ofs", int'(max_ofs), VEC[v][5]);
      check("R7 opt_tap", int'(opt_tap), VEC[v][6]);
      check("R5 R6 inc count", incs, VEC[v][7]);
      if (incs > 1) check("R8 inc spacing ok", int'(min_gap >= 4), 1);
    end

    // R8: single-cycle pulses, counted cycle by cycle
    begin
      int hi = 0;
      int rises = 0;
      logic prev = 1'b0;
      do_reset(3, 5, 8);
      start = 1'b1;
      for (int k = 0; k < 400 && !done; k++) begin
        @(negedge clk);
        if (inc_en) begin
          hi++;
          if (!prev) rises++;
          tap_in  = tap_in + TAP_W'(1);
          rx_word = word_at(3, 5, 8, int'(tap_in));
        end
        prev = inc_en;
      end
      check("R8 high cycles per pulse", hi, rises);
      check("R8 pulse count", rises, 13);
    end

    // R9: results frozen after done
    begin
      int incs_after = 0;
      int lost_done = 0;
      logic [18:0] snap;
      snap = {pulse_idx, min_dly, max_ofs, opt_tap};
      for (int k = 0; k < 60; k++) begin
        rx_word = (k % 2 == 0) ? '1 : WORD_W'(1 << (k % WORD_W));
        tap_in  = TAP_W'(k);
        start   = k[1];
        @(negedge clk);
        if (inc_en) incs_after++;
        if (!done) lost_done++;
      end
      check("R9 inc after done", incs_after, 0);
      check("R9 done held", lost_done, 0);
      check("R9 results held", int'({pulse_idx, min_dly, max_ofs, opt_tap}), int'(snap));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule